// File: doc/BRIEF.md
# Bus configuration and interrupt gating registers

This block is a small register file on a simple CPU register bus. Software sets it up once after reset. It holds the working bus mode, the CPU addressing mode, one output enable for each chip-enable terminal, the stack page and the enable for the bus request/grant function. From these fields it drives the pin-function selects. Each shared terminal carries either its bus signal or a general port bit.

A strap input tells the block whether the device runs as a microcontroller (strap 1) or as a microprocessor (strap 0). The strap picks the reset values, and in microprocessor mode it forces the bus into expansion mode.

The block also gates every interrupt line, the non-maskable one included. The gate stays closed until software has written both the mode register and the stack page register. Each stack page write keeps the gate closed until the next instruction boundary. A non-maskable request that arrives while the gate is closed is held, and it is delivered as soon as the gate opens.

Top module: `busctl_top`

## Requirements
- R1: Reset with strap 1 (microcontroller) gives these read values: offset 0 reads 80h (bus mode bit 7 = 1, single chip; CPU mode bit 6 = 0, minimum; chip-enable enables in bits 2..0 = 000), offset 1 reads 00h and offset 2 reads 00h. After reset the interrupt gate is closed.
- R2: Reset with strap 0 (microprocessor) makes offset 0 read 01h. With strap 0, single_chip stays 0 whatever bus mode bit 7 holds, and stack page writes are treated as in expansion mode.
- R3: A write to offset 0 stores bit 7 (bus mode), bit 6 (CPU mode) and bits 2..0 (chip-enable enables). Bits 5..3 read 0. single_chip equals strap AND bit 7, and cpu_max equals bit 6.
- R4: In expansion mode a stack page write (offset 1) stores the written value when it is at most 27h, and stores 27h when it is larger.
- R5: In single chip mode any stack page write stores 00h.
- R6: For each chip-enable terminal i, ce_pin[i] follows ce_bus[i] when enable bit i is 1 and follows port_r[i] when it is 0.
- R7: Offset 2 bit 7 is the bus request/grant enable; bits 6..0 read 0. When the enable is 1: breq_req follows breq_pin, kport_in is 0 and back_pin follows bus_grant. When it is 0: breq_req is 0, kport_in follows breq_pin and back_pin follows port_r[3].
- R8: While offset 0 and offset 1 have not both been written since reset, irq_out is all zero, nmi_out is 0 and int_gate_open is 0.
- R9: After a write to offset 1, the gate stays closed until insn_done has been sampled high on a later clock edge. It reopens after that edge, provided R8 is met.
- R10: An NMI that is high while the gate is closed is held. nmi_out is then 1 for exactly one cycle once the gate opens, provided nmi_in is low by then.
- R11: A write to offset 3 changes no stored field, and offset 3 reads 00h.
- R12: Writes take effect on the clock edge at which wr_en is sampled high. Reads are combinational from the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mcu | input | 1 | 1 = microcontroller mode, 0 = microprocessor mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| insn_done | input | 1 | Instruction boundary marker |
| irq_in | input | 8 | Maskable interrupt requests |
| nmi_in | input | 1 | Non-maskable interrupt request |
| irq_out | output | 8 | Gated maskable interrupts |
| nmi_out | output | 1 | Gated non-maskable interrupt |
| int_gate_open | output | 1 | Interrupt gate open |
| single_chip | output | 1 | Effective single chip mode |
| cpu_max | output | 1 | CPU maximum addressing mode |
| ce_bus | input | 3 | Chip-enable levels from the bus sequencer |
| port_r | input | 4 | General output port bits for the shared terminals |
| ce_pin | output | 3 | Chip-enable terminal levels |
| breq_pin | input | 1 | Bus request terminal level |
| bus_grant | input | 1 | Grant level from the bus sequencer |
| breq_req | output | 1 | Bus request passed to the sequencer |
| kport_in | output | 1 | Input port bit taken from the request terminal |
| back_pin | output | 1 | Grant terminal level |

## Verification
The assertions check on every cycle that the stack page never exceeds its limit. They also check that a single chip stack write leaves 00h and that an offset 3 write leaves all fields unchanged. Further assertions check that a stack page write closes the gate on the next cycle, that a blocked NMI is not lost, and that the chip-enable terminals carry port bits when disabled. Only the bench scenarios can show the reset values under both strap settings and the exact order of gate opening across the two configuration writes and the instruction boundary. The same holds for the one-cycle release of a held NMI and the full read-back encodings.

// File: rtl/busctl_pkg.sv
// Package: shared offsets, field positions and decode type for the bus
// configuration block. Assumes an 8-bit register bus with 2 offset bits.
package busctl_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned ADDR_W     = 2;
    localparam int unsigned BIT_BUSMOD = 7;
    localparam int unsigned BIT_CPUMOD = 6;
    localparam int unsigned BIT_EBR    = 7;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_STACK = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_BREQ  = 2'd2;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_STACK = 2'd1,
        SEL_BREQ  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Map a register offset onto the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MODE:  return SEL_MODE;
            OFS_STACK: return SEL_STACK;
            OFS_BREQ:  return SEL_BREQ;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/busctl_regs.sv
// Module: busctl_regs
// Holds the mode, stack page and bus-request registers and builds read data.
// Assumes NUM_CE <= 6 so the enables do not overlap the mode bits.
// Reset values come from strap_mcu at the reset edge.
module busctl_regs
    import busctl_pkg::*;
#(
    parameter int unsigned NUM_CE    = 3,
    parameter logic [7:0]  STACK_MAX = 8'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_mcu,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CE-1:0] ce_en,
    output logic              ebr,
    output logic              single_chip,
    output logic              cpu_max,
    output logic              wr_mode,
    output logic              wr_stack
);
    localparam logic [NUM_CE-1:0] CE_RST_MCU = '0;
    localparam logic [NUM_CE-1:0] CE_RST_MPU = {{(NUM_CE-1){1'b0}}, 1'b1};

    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic              busmod;
    logic              cpumod;
    logic [DATA_W-1:0] stack_page;
    logic [DATA_W-1:0] stack_next;

    // Decode the write target and the read target.
    always_comb begin
        wsel     = decode_ofs(addr);
        rsel     = decode_ofs(addr);
        wr_mode  = wr_en && (wsel == SEL_MODE);
        wr_stack = wr_en && (wsel == SEL_STACK);
    end

    // Effective mode: microprocessor strap forces expansion.
    always_comb begin
        single_chip = strap_mcu & busmod;
        cpu_max     = cpumod;
    end

    // Legalise a stack page write against the current bus mode.
    always_comb begin
        if (single_chip)
            stack_next = '0;
        else if (wdata > STACK_MAX)
            stack_next = STACK_MAX;
        else
            stack_next = wdata;
    end

    // Mode register: bus mode, CPU mode and chip-enable enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busmod <= strap_mcu;
            cpumod <= 1'b0;
            ce_en  <= strap_mcu ? CE_RST_MCU : CE_RST_MPU;
        end else if (wr_mode) begin
            busmod <= wdata[BIT_BUSMOD];
            cpumod <= wdata[BIT_CPUMOD];
            ce_en  <= wdata[NUM_CE-1:0];
        end
    end

    // Stack page register with legalised write value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stack_page <= '0;
        else if (wr_stack)
            stack_page <= stack_next;
    end

    // Bus request/grant enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ebr <= 1'b0;
        else if (wr_en && (wsel == SEL_BREQ))
            ebr <= wdata[BIT_EBR];
    end

    // Combinational read mux from the stored fields.
    always_comb begin
        rdata = '0;
        case (rsel)
            SEL_MODE: begin
                rdata[BIT_BUSMOD]  = busmod;
                rdata[BIT_CPUMOD]  = cpumod;
                rdata[NUM_CE-1:0]  = ce_en;
            end
            SEL_STACK: rdata = stack_page;
            SEL_BREQ:  rdata[BIT_EBR] = ebr;
            default:   rdata = '0;
        endcase
    end

    // R4: the stored stack page never exceeds the legal limit.
    assert_stack_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stack_page <= STACK_MAX);

    // R5: a stack write in single chip mode leaves page zero.
    assert_single_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stack && single_chip) |=> (stack_page == '0));

    // R11: a write to the unused offset leaves every field unchanged.
    assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_NONE) |=>
            ($stable(stack_page) && $stable(ce_en) && $stable(ebr) &&
             $stable(busmod) && $stable(cpumod)));
endmodule

// File: rtl/busctl_irq_gate.sv
// Module: busctl_irq_gate
// Blocks all interrupts, NMI included, until both configuration registers have
// been written, and for one instruction after each stack page write. Keeps a
// blocked NMI pending. Assumes insn_done pulses once per instruction boundary.
module busctl_irq_gate #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mode,
    input  logic               wr_stack,
    input  logic               insn_done,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               nmi_in,
    output logic [NUM_IRQ-1:0] irq_out,
    output logic               nmi_out,
    output logic               gate_open
);
    logic seen_mode;
    logic seen_stack;
    logic hold;
    logic nmi_pend;

    // Remember that each configuration register has been written once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_mode  <= 1'b0;
            seen_stack <= 1'b0;
        end else begin
            if (wr_mode)  seen_mode  <= 1'b1;
            if (wr_stack) seen_stack <= 1'b1;
        end
    end

    // Keep the gate shut from a stack write to the next instruction boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= 1'b0;
        else if (wr_stack)
            hold <= 1'b1;
        else if (insn_done)
            hold <= 1'b0;
    end

    // Gate state from the configuration flags and the post-write hold.
    always_comb gate_open = seen_mode & seen_stack & ~hold;

    // Latch an NMI that meets a closed gate; clear once delivered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_pend <= 1'b0;
        else if (gate_open)
            nmi_pend <= 1'b0;
        else if (nmi_in)
            nmi_pend <= 1'b1;
    end

    // Gated outputs toward the interrupt controller.
    always_comb begin
        irq_out = gate_open ? irq_in : '0;
        nmi_out = gate_open & (nmi_in | nmi_pend);
    end

    // R9: a stack page write closes the gate on the following cycle.
    assert_stack_write_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stack |=> !gate_open);

    // R10: an NMI blocked by the closed gate is kept until delivery.
    assert_nmi_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && !gate_open) |=> (nmi_pend || nmi_out));

    // R8: the gate cannot open before both registers have been written.
    assert_gate_needs_config_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> ($past(seen_mode || wr_mode) && $past(seen_stack || wr_stack)));
endmodule

// File: rtl/busctl_pinmux.sv
// Module: busctl_pinmux
// Chooses the function of each shared terminal: bus signal or general port.
// Purely combinational; assumes port_r carries NUM_CE chip-enable port bits
// plus one more bit, at the top, for the grant terminal.
module busctl_pinmux #(
    parameter int unsigned NUM_CE = 3
) (
    input  logic [NUM_CE-1:0] ce_en,
    input  logic              ebr,
    input  logic [NUM_CE-1:0] ce_bus,
    input  logic [NUM_CE:0]   port_r,
    input  logic              breq_pin,
    input  logic              bus_grant,
    output logic [NUM_CE-1:0] ce_pin,
    output logic              breq_req,
    output logic              kport_in,
    output logic              back_pin
);
    // One selector per chip-enable terminal.
    for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
        always_comb ce_pin[i] = ce_en[i] ? ce_bus[i] : port_r[i];
    end

    // Request and grant terminals switch between bus and port roles.
    always_comb begin
        breq_req = ebr & breq_pin;
        kport_in = ~ebr & breq_pin;
        back_pin = ebr ? bus_grant : port_r[NUM_CE];
    end

    // R6: with every enable cleared the terminals carry the port bits.
    always_comb begin
        if (ce_en == '0)
            assert_ce_port_R6: assert (ce_pin == port_r[NUM_CE-1:0]);
    end
endmodule

// File: rtl/busctl_top.sv
// Module: busctl_top
// Bus configuration register file with interrupt gating and pin selects.
// Assumes a single-cycle write strobe on a register bus and a synchronous
// active-low reset during which strap_mcu is stable.
module busctl_top
    import busctl_pkg::*;
#(
    parameter int unsigned NUM_CE    = 3,
    parameter int unsigned NUM_IRQ   = 8,
    parameter logic [7:0]  STACK_MAX = 8'h27
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_mcu,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               insn_done,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               nmi_in,
    output logic [NUM_IRQ-1:0] irq_out,
    output logic               nmi_out,
    output logic               int_gate_open,
    output logic               single_chip,
    output logic               cpu_max,
    input  logic [NUM_CE-1:0]  ce_bus,
    input  logic [NUM_CE:0]    port_r,
    output logic [NUM_CE-1:0]  ce_pin,
    input  logic               breq_pin,
    input  logic               bus_grant,
    output logic               breq_req,
    output logic               kport_in,
    output logic               back_pin
);
    logic [NUM_CE-1:0] ce_en;
    logic              ebr;
    logic              wr_mode;
    logic              wr_stack;

    busctl_regs #(.NUM_CE(NUM_CE), .STACK_MAX(STACK_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_mcu(strap_mcu),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ce_en(ce_en), .ebr(ebr), .single_chip(single_chip),
        .cpu_max(cpu_max), .wr_mode(wr_mode), .wr_stack(wr_stack)
    );

    busctl_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_stack(wr_stack),
        .insn_done(insn_done), .irq_in(irq_in), .nmi_in(nmi_in),
        .irq_out(irq_out), .nmi_out(nmi_out), .gate_open(int_gate_open)
    );

    busctl_pinmux #(.NUM_CE(NUM_CE)) u_mux (
        .ce_en(ce_en), .ebr(ebr), .ce_bus(ce_bus), .port_r(port_r),
        .breq_pin(breq_pin), .bus_grant(bus_grant), .ce_pin(ce_pin),
        .breq_req(breq_req), .kport_in(kport_in), .back_pin(back_pin)
    );
endmodule

// File: tb/busctl_top_test.sv
module busctl_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_mcu = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       insn_done = 1'b0;
    logic [7:0] irq_in = 8'hA5;
    logic       nmi_in = 1'b0;
    logic [7:0] irq_out;
    logic       nmi_out, int_gate_open, single_chip, cpu_max;
    logic [2:0] ce_bus = 3'b111;
    logic [3:0] port_r = 4'b1000;
    logic [2:0] ce_pin;
    logic       breq_pin = 1'b1;
    logic       bus_grant = 1'b0;
    logic       breq_req, kport_in, back_pin;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    busctl_top uut (
        .clk(clk), .rst_n(rst_n), .strap_mcu(strap_mcu), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .insn_done(insn_done),
        .irq_in(irq_in), .nmi_in(nmi_in), .irq_out(irq_out), .nmi_out(nmi_out),
        .int_gate_open(int_gate_open), .single_chip(single_chip),
        .cpu_max(cpu_max), .ce_bus(ce_bus), .port_r(port_r), .ce_pin(ce_pin),
        .breq_pin(breq_pin), .bus_grant(bus_grant), .breq_req(breq_req),
        .kport_in(kport_in), .back_pin(back_pin)
    );

    // Vector: {addr[17:16], wdata[15:8], expected read-back[7:0]}; strap 1.
    localparam int NVEC = 12;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd0, 8'hFF, 8'hC7},   // R3 reserved bits read 0, single chip
        {2'd1, 8'h15, 8'h00},   // R5 single chip forces page 0
        {2'd0, 8'h40, 8'h40},   // R3 expansion, maximum
        {2'd1, 8'h15, 8'h15},   // R4 legal page kept
        {2'd1, 8'h27, 8'h27},   // R4 limit kept
        {2'd1, 8'h28, 8'h27},   // R4 clamped
        {2'd1, 8'hFF, 8'h27},   // R4 clamped
        {2'd2, 8'hFF, 8'h80},   // R7 only bit 7 stored
        {2'd2, 8'h7F, 8'h00},   // R7 low bits ignored
        {2'd3, 8'hFF, 8'h00},   // R11 unused offset
        {2'd1, 8'h00, 8'h00},   // R4 zero page
        {2'd0, 8'h85, 8'h85}    // R3 enables 101
    };
    localparam int VREQ [NVEC] = '{3, 5, 3, 4, 4, 4, 4, 7, 7, 11, 4, 3};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write one register; returns at the negedge after the write edge (R12).
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, {24'h0, rdata}, {24'h0, exp});
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        strap_mcu = strap; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic insn_pulse();
        @(negedge clk);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        // R1 reset state, microcontroller strap
        rd_check("R1", 2'd0, 8'h80);
        rd_check("R1", 2'd1, 8'h00);
        rd_check("R1", 2'd2, 8'h00);
        check("R1", {31'h0, int_gate_open}, 32'h0);
        check("R8", {24'h0, irq_out}, 32'h0);

        // R8: stack page written and boundary passed, mode still missing
        wr(2'd1, 8'h00);
        insn_pulse();
        check("R8", {24'h0, irq_out}, 32'h0);
        // R10: NMI while closed is held
        @(negedge clk); nmi_in = 1'b1;
        #1 check("R10", {31'h0, nmi_out}, 32'h0);
        @(negedge clk); nmi_in = 1'b0;
        // mode write completes configuration: gate opens after that edge
        wr(2'd0, 8'h80);
        check("R8", {24'h0, irq_out}, 32'hA5);
        check("R10", {31'h0, nmi_out}, 32'h1);
        @(negedge clk);
        check("R10", {31'h0, nmi_out}, 32'h0);
        // R9: stack write recloses until an instruction boundary
        wr(2'd1, 8'h00);
        check("R9", {31'h0, int_gate_open}, 32'h0);
        @(negedge clk);
        check("R9", {24'h0, irq_out}, 32'h0);
        insn_pulse();
        check("R9", {31'h0, int_gate_open}, 32'h1);

        // Register table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd_check($sformatf("R%0d", VREQ[i]), VEC[i][17:16], VEC[i][7:0]);
        end
        check("R3", {31'h0, single_chip}, 32'h1);
        check("R3", {31'h0, cpu_max}, 32'h0);

        // R6: enables 101 with bus 111 and port 000
        #1 check("R6", {29'h0, ce_pin}, 32'h5);
        // R7: request/grant disabled
        check("R7", {29'h0, breq_req, kport_in, back_pin}, 32'b011);
        wr(2'd2, 8'h80);
        check("R7", {29'h0, breq_req, kport_in, back_pin}, 32'b100);

        // R2: microprocessor strap
        do_reset(1'b0);
        rd_check("R2", 2'd0, 8'h01);
        check("R2", {31'h0, single_chip}, 32'h0);
        check("R6", {29'h0, ce_pin}, 32'h1);
        wr(2'd0, 8'h80);
        check("R2", {31'h0, single_chip}, 32'h0);
        wr(2'd1, 8'h10);
        rd_check("R2", 2'd1, 8'h10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule